// File: doc/BRIEF.md
# Sixteen-bit capture/compare timer with dual-slope PWM

This block is a 16-bit timer/counter that a processor reaches over a small byte-wide register port. A clock-select field picks one of eight sources for the count. The count can be stopped, can run on every system clock or on one of four divided rates, or can follow edges on an external pin. A single compare channel drives one output pin. An input-capture channel copies the running count into a holding register when the selected edge appears on a capture pin, and a four-sample noise filter can be placed in front of that edge detector.

In normal mode the counter counts up and wraps from 0xFFFF to zero. An option clears it after it reaches the compare value. In PWM mode it counts up and down between zero and a top value of 255, 511 or 1023. Overflow, compare-match and capture events each set a sticky flag, and each flag has its own interrupt enable. Software writes and reads the 16-bit registers as two bytes through one shared high-byte latch, so a 16-bit access is never torn.

Register map (byte addresses on `bus_addr`):

- 0x0 mode: bits [1:0] PWM width, bits [3:2] compare pin action.
- 0x1 clocking: bits [2:0] clock select, bit 3 clear-on-match, bit 4 capture on rise, bit 5 filter enable.
- 0x2 / 0x3 count, low and high byte.
- 0x4 / 0x5 compare, low and high byte.
- 0x6 / 0x7 capture, low and high byte, read only.
- 0x8 flags.
- 0x9 interrupt enables.

In the flag and enable registers, bit 0 is overflow, bit 1 is compare match and bit 2 is capture.

Top module: `cap_cmp_timer`

## Requirements
- R1: Clock select (register 0x1, bits [2:0]) advances the counter as follows: 0 never, 1 on every clock, 2 once every 8 clocks, 3 once every 64, 4 once every 256, 5 once every 1024. Any write to register 0x1 restarts the divider, so after the write the counter has advanced floor(N/D) times in N clocks.
- R2: Clock select 6 advances the counter once per falling edge of `ext_clk_in`, and 7 once per rising edge. The pin passes through a two-flop synchronizer before the edge detector.
- R3: Compare pin action (register 0x0, bits [3:2]) works as follows. 0 deasserts `cmp_oe` and holds `cmp_out` low. 1 toggles the pin on each match, 2 clears it and 3 sets it. A match is a counter advance while the count equals the compare value.
- R4: PWM width (register 0x0, bits [1:0]) selects the mode: 1, 2 and 3 give 8-, 9- and 10-bit dual-slope counting with top values 255, 511 and 1023, and 0 gives normal mode. The counter turns down at the top and turns up at zero, and overflow is raised at the zero turn. In PWM mode, action 2 clears the pin on an up-count match and sets it on a down-count match, and action 3 does the reverse.
- R5: A capture event copies the count into the capture register and sets flag bit 2. Register 0x1 bit 4 picks the edge: 1 means rising, 0 means falling. An edge of the other polarity has no effect.
- R6: With register 0x1 bit 5 set, the capture level changes only after four equal consecutive samples, so a 2-clock pulse is ignored. With the bit clear, the same pulse is captured.
- R7: In normal mode with register 0x1 bit 3 set, an advance while the count equals the compare value loads zero instead of incrementing.
- R8: Flags are set by their events and cleared only by writing 1 to their bit at 0x8; writing 0 leaves them unchanged. Each interrupt output is its flag AND its enable bit at 0x9.
- R9: Writing a high byte (0x3 or 0x5) only loads a shared latch. Writing the matching low byte commits all 16 bits. Reading a low byte (0x2 or 0x6) latches the matching high byte, and reading the high byte returns that latch.
- R10: In normal mode an advance from 0xFFFF gives zero and sets the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; its only side effect is the high-byte latch |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| ext_clk_in | input | 1 | External count source, asynchronous |
| cap_in | input | 1 | Capture trigger pin, asynchronous |
| cmp_out | output | 1 | Compare output pin level |
| cmp_oe | output | 1 | Compare output enable |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare-match interrupt request |
| irq_cap | output | 1 | Capture interrupt request |

## Verification
Several rules are checked by properties on every cycle:

- A stopped prescaler never ticks, and divide-by-8 ticks and external-edge ticks never come back to back.
- A capture event lasts one cycle.
- The counter turns down from the PWM top value, and it clears after a compare match in clear mode.
- The counter wraps to zero at 0xFFFF, and a flag stays set unless software writes a 1 to its bit.
- A low-byte read latches the high byte.

Other behaviour only shows in the bench's directed scenarios, all observed through the register port:

- exact tick counts for each divider;
- counted external edges;
- the pin level after a given number of matches;
- the captured values with the filter on and off;
- the dual-slope count after hundreds of ticks;
- untorn 16-bit reads while the counter runs.

// File: rtl/tmr_pkg.sv
// Package: shared encodings and register addresses for the capture/compare timer.
// Assumes a byte-wide register port with 4-bit addresses.
package tmr_pkg;
    typedef enum logic [1:0] {PIN_OFF = 2'd0, PIN_TOGGLE = 2'd1, PIN_CLEAR = 2'd2, PIN_SET = 2'd3} pin_act_e;
    typedef enum logic [1:0] {PWM_NONE = 2'd0, PWM_W8 = 2'd1, PWM_W9 = 2'd2, PWM_W10 = 2'd3} pwm_w_e;

    localparam logic [3:0] A_MODE   = 4'h0;
    localparam logic [3:0] A_CLKCFG = 4'h1;
    localparam logic [3:0] A_CNT_LO = 4'h2;
    localparam logic [3:0] A_CNT_HI = 4'h3;
    localparam logic [3:0] A_CMP_LO = 4'h4;
    localparam logic [3:0] A_CMP_HI = 4'h5;
    localparam logic [3:0] A_CAP_LO = 4'h6;
    localparam logic [3:0] A_CAP_HI = 4'h7;
    localparam logic [3:0] A_FLAGS  = 4'h8;
    localparam logic [3:0] A_IRQEN  = 4'h9;

    localparam int FLG_OVF = 0;
    localparam int FLG_CMP = 1;
    localparam int FLG_CAP = 2;
    localparam int FLG_N   = 3;
endpackage

// File: rtl/tmr_prescaler.sv
// Module: tmr_prescaler
// Turns the 3-bit clock select into a one-cycle count tick.
// Divided rates come from one free-running divider that restarts on clr.
// External edges are synchronized through two flops before detection.
// Assumes DIV_W >= 10 so that the divide-by-1024 tap exists.
module tmr_prescaler #(
    parameter int DIV_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [2:0] sel,
    input  logic       ext_pin,
    output logic       tick
);
    logic [DIV_W-1:0] div_q;
    logic             ext_s1, ext_s2, ext_prev;

    // Free-running divider, restarted by reset or a clock-select write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) div_q <= '0;
        else               div_q <= div_q + DIV_W'(1);
    end

    // Two-flop synchronizer plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_s1   <= 1'b0;
            ext_s2   <= 1'b0;
            ext_prev <= 1'b0;
        end else begin
            ext_s1   <= ext_pin;
            ext_s2   <= ext_s1;
            ext_prev <= ext_s2;
        end
    end

    // Tick selection per clock-select code.
    always_comb begin
        case (sel)
            3'd1:    tick = 1'b1;
            3'd2:    tick = &div_q[2:0];
            3'd3:    tick = &div_q[5:0];
            3'd4:    tick = &div_q[7:0];
            3'd5:    tick = &div_q[9:0];
            3'd6:    tick = ext_prev & ~ext_s2;
            3'd7:    tick = ~ext_prev & ext_s2;
            default: tick = 1'b0;
        endcase
    end

    p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd0) |-> !tick);
    p_div8_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd2 && $past(sel) == 3'd2 && $past(tick) && !$past(clr)) |-> !tick);
    p_ext_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd7 && $past(sel) == 3'd7 && $past(tick)) |-> !tick);
endmodule

// File: rtl/tmr_capture.sv
// Module: tmr_capture
// Synchronizes the capture pin and optionally filters it.
// With the filter on, the level changes only after FILT_N equal samples.
// Emits a one-cycle event on the selected edge of the resulting level.
module tmr_capture #(
    parameter int FILT_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic filt_en,
    input  logic on_rise,
    output logic evt
);
    logic              s1, s2, filt_q, lvl, lvl_prev;
    logic [FILT_N-1:0] hist_q;

    // Synchronizer and sample history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1     <= 1'b0;
            s2     <= 1'b0;
            hist_q <= '0;
        end else begin
            s1     <= pin;
            s2     <= s1;
            hist_q <= {hist_q[FILT_N-2:0], s2};
        end
    end

    // Filtered level: moves only when the whole history agrees.
    always_ff @(posedge clk) begin
        if (!rst_n)            filt_q <= 1'b0;
        else if (&hist_q)      filt_q <= 1'b1;
        else if (~|hist_q)     filt_q <= 1'b0;
    end

    assign lvl = filt_en ? filt_q : s2;

    // Previous level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= 1'b0;
        else        lvl_prev <= lvl;
    end

    assign evt = on_rise ? (lvl & ~lvl_prev) : (~lvl & lvl_prev);

    p_evt_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt) && $stable(on_rise) && $stable(filt_en)) |-> !evt);
endmodule

// File: rtl/tmr_core.sv
// Module: tmr_core
// Counter with normal/clear-on-match/dual-slope PWM modes and compare-pin logic.
// Advances on tick. A software write has priority and restarts the up direction.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  pwm_w_e           pwm_w,
    input  pin_act_e         pin_act,
    input  logic             clr_on_match,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_evt,
    output logic             match_evt,
    output logic             pin_lvl
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             up_q, up_n, pin_n, adv, at_top;
    logic [CNT_W-1:0] cnt_n, top_val;

    assign adv = tick & ~cnt_wr;

    // Top value for the selected PWM width.
    always_comb begin
        case (pwm_w)
            PWM_W8:  top_val = CNT_W'(255);
            PWM_W9:  top_val = CNT_W'(511);
            PWM_W10: top_val = CNT_W'(1023);
            default: top_val = '1;
        endcase
    end

    assign at_top = (cnt >= top_val);

    // Next count, direction and overflow event.
    always_comb begin
        cnt_n   = cnt;
        up_n    = up_q;
        ovf_evt = 1'b0;
        if (pwm_w == PWM_NONE) begin
            up_n = 1'b1;
            if (adv) begin
                ovf_evt = (cnt == '1);
                cnt_n   = (clr_on_match && cnt == cmp_val) ? '0 : cnt + ONE;
            end
        end else if (adv) begin
            if (up_q) begin
                if (at_top) begin
                    up_n  = 1'b0;
                    cnt_n = cnt - ONE;
                end else begin
                    cnt_n = cnt + ONE;
                end
            end else if (cnt == '0) begin
                up_n    = 1'b1;
                cnt_n   = ONE;
                ovf_evt = 1'b1;
            end else begin
                cnt_n = cnt - ONE;
            end
        end
    end

    assign match_evt = adv && (cnt == cmp_val);

    // Pin action on a compare match.
    always_comb begin
        pin_n = pin_lvl;
        if (match_evt) begin
            case (pin_act)
                PIN_TOGGLE: pin_n = ~pin_lvl;
                PIN_CLEAR:  pin_n = (pwm_w != PWM_NONE) ? ~up_q : 1'b0;
                PIN_SET:    pin_n = (pwm_w != PWM_NONE) ? up_q : 1'b1;
                default:    pin_n = pin_lvl;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            up_q    <= 1'b1;
            pin_lvl <= 1'b0;
        end else begin
            pin_lvl <= pin_n;
            if (cnt_wr) begin
                cnt  <= cnt_wdata;
                up_q <= 1'b1;
            end else begin
                cnt  <= cnt_n;
                up_q <= up_n;
            end
        end
    end

    p_pwm_peak_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_w != PWM_NONE && adv && up_q && cnt == top_val) |=> (cnt == $past(top_val) - ONE));
    p_ctc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_w == PWM_NONE && adv && clr_on_match && cnt == cmp_val) |=> (cnt == '0));
    p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_w == PWM_NONE && adv && cnt == '1 && !(clr_on_match && cmp_val == '1)) |=> (cnt == '0));
endmodule

// File: rtl/cap_cmp_timer.sv
// Module: cap_cmp_timer (top)
// Register file, flags and interrupt requests around prescaler, capture and core.
// Assumes at most one of bus_wr and bus_rd is active per cycle.
module cap_cmp_timer
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 10,
    parameter int FILT_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_clk_in,
    input  logic              cap_in,
    output logic              cmp_out,
    output logic              cmp_oe,
    output logic              irq_ovf,
    output logic              irq_cmp,
    output logic              irq_cap
);
    localparam int CNT_W = 2 * BYTE_W;

    pwm_w_e             pwm_q;
    pin_act_e           act_q;
    logic [2:0]         sel_q;
    logic               clr_q, rise_q, filt_q;
    logic [CNT_W-1:0]   cmp_q, cap_q, cnt;
    logic [BYTE_W-1:0]  tmp_q;
    logic [FLG_N-1:0]   flags_q, irqen_q, evts, w1c;
    logic               tick, cap_evt, ovf_evt, match_evt, pin_lvl;
    logic               wr_clk, cnt_wr;

    assign wr_clk = bus_wr && bus_addr == A_CLKCFG;
    assign cnt_wr = bus_wr && bus_addr == A_CNT_LO;

    tmr_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .clr(wr_clk), .sel(sel_q),
        .ext_pin(ext_clk_in), .tick(tick));

    tmr_capture #(.FILT_N(FILT_N)) u_cap (
        .clk(clk), .rst_n(rst_n), .pin(cap_in), .filt_en(filt_q),
        .on_rise(rise_q), .evt(cap_evt));

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_w(pwm_q), .pin_act(act_q),
        .clr_on_match(clr_q), .cmp_val(cmp_q), .cnt_wr(cnt_wr),
        .cnt_wdata({tmp_q, bus_wdata}), .cnt(cnt), .ovf_evt(ovf_evt),
        .match_evt(match_evt), .pin_lvl(pin_lvl));

    // Configuration and compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q  <= PWM_NONE;
            act_q  <= PIN_OFF;
            sel_q  <= 3'd0;
            clr_q  <= 1'b0;
            rise_q <= 1'b0;
            filt_q <= 1'b0;
            cmp_q  <= '0;
            irqen_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_MODE: begin
                    pwm_q <= pwm_w_e'(bus_wdata[1:0]);
                    act_q <= pin_act_e'(bus_wdata[3:2]);
                end
                A_CLKCFG: begin
                    sel_q  <= bus_wdata[2:0];
                    clr_q  <= bus_wdata[3];
                    rise_q <= bus_wdata[4];
                    filt_q <= bus_wdata[5];
                end
                A_CMP_LO: cmp_q   <= {tmp_q, bus_wdata};
                A_IRQEN:  irqen_q <= bus_wdata[FLG_N-1:0];
                default: ;
            endcase
        end
    end

    // Shared high-byte latch: loaded by high-byte writes and low-byte reads.
    always_ff @(posedge clk) begin
        if (!rst_n) tmp_q <= '0;
        else if (bus_wr && (bus_addr == A_CNT_HI || bus_addr == A_CMP_HI)) tmp_q <= bus_wdata;
        else if (bus_rd && bus_addr == A_CNT_LO) tmp_q <= cnt[CNT_W-1:BYTE_W];
        else if (bus_rd && bus_addr == A_CAP_LO) tmp_q <= cap_q[CNT_W-1:BYTE_W];
    end

    // Capture register.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (cap_evt) cap_q <= cnt;
    end

    // Sticky flags: events set, write-one clears, set wins.
    assign evts = {cap_evt, match_evt, ovf_evt};
    assign w1c  = (bus_wr && bus_addr == A_FLAGS) ? bus_wdata[FLG_N-1:0] : '0;
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~w1c) | evts;
    end

    // Read-data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE:   bus_rdata = BYTE_W'({act_q, pwm_q});
            A_CLKCFG: bus_rdata = BYTE_W'({filt_q, rise_q, clr_q, sel_q});
            A_CNT_LO: bus_rdata = cnt[BYTE_W-1:0];
            A_CNT_HI: bus_rdata = tmp_q;
            A_CMP_LO: bus_rdata = cmp_q[BYTE_W-1:0];
            A_CMP_HI: bus_rdata = cmp_q[CNT_W-1:BYTE_W];
            A_CAP_LO: bus_rdata = cap_q[BYTE_W-1:0];
            A_CAP_HI: bus_rdata = tmp_q;
            A_FLAGS:  bus_rdata = BYTE_W'(flags_q);
            A_IRQEN:  bus_rdata = BYTE_W'(irqen_q);
            default:  bus_rdata = '0;
        endcase
    end

    assign cmp_oe  = (act_q != PIN_OFF);
    assign cmp_out = cmp_oe & pin_lvl;
    assign irq_ovf = flags_q[FLG_OVF] & irqen_q[FLG_OVF];
    assign irq_cmp = flags_q[FLG_CMP] & irqen_q[FLG_CMP];
    assign irq_cap = flags_q[FLG_CAP] & irqen_q[FLG_CAP];

    for (genvar g = 0; g < FLG_N; g++) begin : g_flag_chk
        p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[g] && !w1c[g]) |=> flags_q[g]);
    end
    p_rd_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == A_CNT_LO) |=> (tmp_q == $past(cnt[CNT_W-1:BYTE_W])));
endmodule

// File: tb/cap_cmp_timer_bench.sv
module cap_cmp_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       ext_clk_in = 1'b0, cap_in = 1'b0;
    logic       cmp_out, cmp_oe, irq_ovf, irq_cmp, irq_cap;
    int         n_chk = 0, n_err = 0, cyc = 0;
    logic [7:0] rb;
    logic [15:0] rw;

    localparam logic [3:0] MODE = 4'h0, CLKC = 4'h1, CNTL = 4'h2, CNTH = 4'h3, CMPL = 4'h4,
                           CMPH = 4'h5, CAPL = 4'h6, CAPH = 4'h7, FLG = 4'h8, IEN = 4'h9;

    typedef struct packed {logic [2:0] sel; logic [15:0] gap; logic [15:0] want;} presc_vec_t;
    localparam presc_vec_t PRESC_TAB [9] = '{
        '{3'd1, 16'd9, 16'd10}, '{3'd2, 16'd15, 16'd2}, '{3'd2, 16'd22, 16'd2},
        '{3'd3, 16'd127, 16'd2}, '{3'd4, 16'd255, 16'd1}, '{3'd4, 16'd510, 16'd1},
        '{3'd5, 16'd1023, 16'd1}, '{3'd5, 16'd2046, 16'd1}, '{3'd0, 16'd50, 16'd0}};

    cap_cmp_timer u_cap_cmp_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_in(ext_clk_in),
        .cap_in(cap_in), .cmp_out(cmp_out), .cmp_oe(cmp_oe), .irq_ovf(irq_ovf),
        .irq_cmp(irq_cmp), .irq_cap(irq_cap));

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc > 150000);
        n_err++;
        $display("FAIL watchdog: got %0d cycles, expected below 150000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h, expected %h", req, got, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        rd(lo, l);
        rd(lo + 4'd1, h);
        v = {h, l};
    endtask

    task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
        wr(lo + 4'd1, v[15:8]);
        wr(lo, v[7:0]);
    endtask

    task automatic run(input logic [7:0] cfg, input int gap);
        wr(CLKC, cfg);
        repeat (gap) @(negedge clk);
        wr(CLKC, {cfg[7:3], 3'd0});
    endtask

    task automatic pulse_cap(input int len);
        cap_in = 1'b1;
        repeat (len) @(negedge clk);
        cap_in = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd16(CNTL, rw); check("R9 reset count", rw, 16'h0000);
        rd(FLG, rb); check("R8 reset flags", {8'h0, rb}, 16'h0000);
        #1 check("R3 reset pin", {14'h0, cmp_oe, cmp_out}, 16'h0);
        check("R8 reset irqs", {13'h0, irq_ovf, irq_cmp, irq_cap}, 16'h0);

        // R1 prescaler table
        foreach (PRESC_TAB[i]) begin
            wr16(CNTL, 16'h0000);
            run({5'd0, PRESC_TAB[i].sel}, int'(PRESC_TAB[i].gap));
            rd16(CNTL, rw);
            check($sformatf("R1 sel=%0d gap=%0d", PRESC_TAB[i].sel, PRESC_TAB[i].gap), rw, PRESC_TAB[i].want);
        end

        // R2 external edges
        wr16(CNTL, 16'h0000);
        wr(CLKC, 8'h07);
        for (int k = 0; k < 3; k++) begin
            ext_clk_in = 1'b1; repeat (4) @(negedge clk);
            ext_clk_in = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        wr(CLKC, 8'h00);
        rd16(CNTL, rw); check("R2 rising edges", rw, 16'd3);
        wr16(CNTL, 16'h0000);
        wr(CLKC, 8'h06);
        for (int k = 0; k < 2; k++) begin
            ext_clk_in = 1'b1; repeat (4) @(negedge clk);
            ext_clk_in = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        wr(CLKC, 8'h00);
        rd16(CNTL, rw); check("R2 falling edges", rw, 16'd2);

        // R3/R7 compare pin actions with clear-on-match, compare = 3, 14 ticks
        wr16(CMPL, 16'd3);
        wr(MODE, 8'h0C); wr16(CNTL, 16'h0); wr(FLG, 8'h07);
        run(8'h09, 13);
        #1 check("R3 set action", {15'h0, cmp_out}, 16'h1);
        rd16(CNTL, rw); check("R7 clear on match count", rw, 16'd2);
        rd(FLG, rb); check("R8 compare flag", {15'h0, rb[1]}, 16'h1);
        wr(MODE, 8'h08); wr16(CNTL, 16'h0);
        run(8'h09, 13);
        #1 check("R3 clear action", {15'h0, cmp_out}, 16'h0);
        wr(MODE, 8'h04); wr16(CNTL, 16'h0);
        run(8'h09, 13);
        #1 check("R3 toggle odd", {15'h0, cmp_out}, 16'h1);
        wr16(CNTL, 16'h0);
        run(8'h09, 9);
        #1 check("R3 toggle even", {15'h0, cmp_out}, 16'h1);
        wr(MODE, 8'h00);
        #1 check("R3 disconnected", {14'h0, cmp_oe, cmp_out}, 16'h0);

        // R4 dual-slope PWM, compare = 100, clear action
        wr16(CMPL, 16'd100);
        wr(MODE, 8'h09); wr16(CNTL, 16'h0); wr(FLG, 8'h07);
        run(8'h01, 299);
        rd16(CNTL, rw); check("R4 8-bit after 300 ticks", rw, 16'd210);
        rd(FLG, rb); check("R4 no overflow before bottom", {15'h0, rb[0]}, 16'h0);
        #1 check("R4 pin cleared on up match", {15'h0, cmp_out}, 16'h0);
        wr(MODE, 8'h0A); wr16(CNTL, 16'h0);
        run(8'h01, 599);
        rd16(CNTL, rw); check("R4 9-bit after 600 ticks", rw, 16'd422);
        wr(MODE, 8'h0B); wr16(CNTL, 16'h0); wr(FLG, 8'h07);
        run(8'h01, 2099);
        rd16(CNTL, rw); check("R4 10-bit after 2100 ticks", rw, 16'd54);
        rd(FLG, rb); check("R4 overflow at bottom", {15'h0, rb[0]}, 16'h1);
        #1 check("R4 pin set on down match", {15'h0, cmp_out}, 16'h1);

        // R10 wrap and R8 flags/irqs
        wr(MODE, 8'h00); wr16(CNTL, 16'hFFFE); wr(FLG, 8'h07);
        run(8'h01, 1);
        rd16(CNTL, rw); check("R10 wrap count", rw, 16'h0000);
        rd(FLG, rb); check("R10 overflow flag", {15'h0, rb[0]}, 16'h1);
        #1 check("R8 irq masked", {15'h0, irq_ovf}, 16'h0);
        wr(IEN, 8'h01);
        #1 check("R8 irq enabled", {15'h0, irq_ovf}, 16'h1);
        wr(FLG, 8'h00);
        rd(FLG, rb); check("R8 write zero keeps flag", {15'h0, rb[0]}, 16'h1);
        wr(FLG, 8'h01);
        rd(FLG, rb); check("R8 write one clears", {15'h0, rb[0]}, 16'h0);
        #1 check("R8 irq drops", {15'h0, irq_ovf}, 16'h0);

        // R5 capture edges
        wr(IEN, 8'h04);
        wr16(CNTL, 16'h1234); wr(CLKC, 8'h10); wr(FLG, 8'h07);
        cap_in = 1'b1; repeat (10) @(negedge clk);
        rd16(CAPL, rw); check("R5 rising capture", rw, 16'h1234);
        #1 check("R5 capture irq", {15'h0, irq_cap}, 16'h1);
        wr(CLKC, 8'h00); wr16(CNTL, 16'h2222); wr(FLG, 8'h07);
        cap_in = 1'b0; repeat (10) @(negedge clk);
        rd16(CAPL, rw); check("R5 falling capture", rw, 16'h2222);
        wr16(CNTL, 16'h2BBB); wr(FLG, 8'h07);
        cap_in = 1'b1; repeat (10) @(negedge clk);
        rd(FLG, rb); check("R5 wrong edge no flag", {15'h0, rb[2]}, 16'h0);
        rd16(CAPL, rw); check("R5 wrong edge no capture", rw, 16'h2222);
        cap_in = 1'b0; repeat (10) @(negedge clk);

        // R6 noise filter
        wr(CLKC, 8'h30); wr16(CNTL, 16'h3333); wr(FLG, 8'h07);
        pulse_cap(2);
        rd(FLG, rb); check("R6 short pulse filtered", {15'h0, rb[2]}, 16'h0);
        pulse_cap(8);
        rd16(CAPL, rw); check("R6 long pulse captured", rw, 16'h3333);
        wr(CLKC, 8'h10); wr16(CNTL, 16'h4444); wr(FLG, 8'h07);
        pulse_cap(2);
        rd16(CAPL, rw); check("R6 short pulse unfiltered", rw, 16'h4444);

        // R9 byte-pair atomicity
        wr16(CNTL, 16'h12FF);
        rd(CNTL, rb); check("R9 low byte", {8'h0, rb}, 16'h00FF);
        run(8'h01, 2);
        rd(CNTH, rb); check("R9 latched high byte", {8'h0, rb}, 16'h0012);
        rd16(CNTL, rw); check("R9 count after ticks", rw, 16'h1302);
        wr(CNTH, 8'h55);
        rd16(CNTL, rw); check("R9 high write alone no effect", rw, 16'h1302);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule